// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM that is 16 bits wide, with 16 address bits and separate active-low strobes for the upper and lower byte. The host uses a request/ready handshake. A request is accepted on a rising clock edge where `req` and `ready` are both high. The command, address, write data and per-byte enables are latched in that same edge. `ready` then stays low until the memory cycle and its minimum cycle time have both finished.

On the memory side the controller drives active-low chip select, output enable, write enable and two byte strobes, plus the address bus. The data bus is split into an outgoing word, an incoming word and a drive enable, so the pad ring can build the tri-state buffer. All memory timing comes from nanosecond limits. Each limit is turned into a cycle count at elaboration as ceil(limit / `CLK_PERIOD_NS`), with a minimum of one cycle. A write first holds output enable high for a turnaround window, and only then drives data and pulses write enable. A read holds the strobes for the access window and registers the data at its end.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_be_n` is all ones, `mem_dq_oe` is low and `ready` is high.
- R2: In a write cycle, `mem_ce_n` goes low with `mem_oe_n` high. `mem_we_n` is low only while `mem_ce_n` is low and `mem_oe_n` is high. `mem_dq_oe` is high and `mem_dq_out` is constant for the whole write-enable pulse, and the memory then holds the written word.
- R3: In a read cycle, `mem_ce_n` and `mem_oe_n` are low with `mem_we_n` high for exactly N_ACC = ceil(max(15, 7) / P) cycles. `rd_data` is registered from `mem_dq_in` at the end of that window.
- R4: `req_be[0]=1` drives `mem_be_n[0]` low and selects data bits 7:0. `req_be[1]=1` drives `mem_be_n[1]` low and selects bits 15:8. This applies to both reads and writes, and a write changes only the enabled bytes.
- R5: In a read, a byte whose `req_be` bit is 0 returns zero in `rd_data`. A write with `req_be=2'b00` leaves the memory contents unchanged.
- R6: `mem_dq_oe` is high only while `mem_oe_n` is high. Before the controller drives data, it holds `mem_ce_n` low, `mem_oe_n` high and the bus undriven for exactly N_HZ = ceil(7 / P) cycles.
- R7: While a cycle is in progress, `ready` is low and further requests wait. Successive falling edges of `mem_ce_n` are at least N_CYC = ceil(15 / P) cycles apart.
- R8: `mem_addr` and `mem_be_n` stay constant while `mem_ce_n` is low.
- R9: Every count is ceil(limit_ns / P) with a minimum of one. The write-enable pulse lasts exactly N_WP = ceil(max(10, 8, 10, 9) / P) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high, bit 0 = bits 7:0 |
| rd_data | output | DATA_W | Registered read data |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte strobes, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the controller with a 4 ns clock and a 4-bit address. The 4 ns clock does not divide the 10 ns and 15 ns limits evenly, so the rounding gives turnaround, pulse, access and cycle counts of 2, 3, 4 and 4. The bench measures each of these cycle by cycle against its own arithmetic. With only 16 words, every address is written and then read under every one of the four byte-enable patterns, including the empty pattern. The bench memory model returns garbage until the access window has elapsed, so a capture taken one cycle early is caught.

// File: rtl/sram_ctl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes limits and clock period are positive integer nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WTURN,
        ST_WPULSE
    } seq_state_t;

    // Cycles needed to cover a limit, never fewer than one.
    function automatic int ns_to_cycles(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_waitcnt.sv
// Down counter used for phase lengths and minimum cycle time.
// Loads a value, then decrements once per clock until it reaches zero.
// Assumes load values fit in CNT_W bits.
module sram_ctl_waitcnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load or count down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
// Cycle sequencer: owns the handshake, the phase order and the
// registered control strobes (chip select, output enable, write enable,
// data drive). Assumes phase counters are loaded with length-1.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int N_HZ  = 1,
    parameter int N_WP  = 1,
    parameter int N_ACC = 2,
    parameter int N_CYC = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic             ph_zero,
    input  logic             cyc_zero,
    output logic             ready,
    output logic             launch,
    output logic             finish,
    output logic             capture,
    output logic             ph_load,
    output logic [CNT_W-1:0] ph_val,
    output logic             cyc_load,
    output logic [CNT_W-1:0] cyc_val,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    seq_state_t state_q, state_d;
    logic ce_d, oe_d, we_d, drv_d;

    // Handshake and next-state / next-strobe decode.
    always_comb begin
        ready    = (state_q == ST_IDLE) && cyc_zero;
        launch   = req && ready;
        finish   = ((state_q == ST_RD) || (state_q == ST_WPULSE)) && ph_zero;
        capture  = (state_q == ST_RD) && ph_zero;
        cyc_load = launch;
        cyc_val  = CNT_W'(N_CYC - 1);
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        ce_d     = ce_n;
        oe_d     = oe_n;
        we_d     = we_n;
        drv_d    = dq_oe;
        case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    ce_d    = 1'b0;
                    ph_load = 1'b1;
                    if (req_wr) begin
                        state_d = ST_WTURN;
                        ph_val  = CNT_W'(N_HZ - 1);
                    end else begin
                        state_d = ST_RD;
                        oe_d    = 1'b0;
                        ph_val  = CNT_W'(N_ACC - 1);
                    end
                end
            end
            ST_WTURN: begin
                if (ph_zero) begin
                    state_d = ST_WPULSE;
                    we_d    = 1'b0;
                    drv_d   = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(N_WP - 1);
                end
            end
            ST_WPULSE: begin
                if (ph_zero) begin
                    state_d = ST_IDLE;
                    we_d    = 1'b1;
                    drv_d   = 1'b0;
                    ce_d    = 1'b1;
                end
            end
            ST_RD: begin
                if (ph_zero) begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b1;
                    ce_d    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and glitch-free registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dq_oe   <= 1'b0;
        end else begin
            state_q <= state_d;
            ce_n    <= ce_d;
            oe_n    <= oe_d;
            we_n    <= we_d;
            dq_oe   <= drv_d;
        end
    end

    // R6: never drive while the memory may be driving.
    a_r6_drive_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R2: write enable only inside chip select, with output enable high.
    a_r2_we_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));

    // R6: data drive starts only after the turnaround phase.
    a_r6_turn_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(state_q) == ST_WTURN));

endmodule

// File: rtl/sram_ctl_bus.sv
// Address, byte-strobe and data registers of the controller.
// Latches the request on launch, releases strobes on finish, and
// captures each read byte lane independently. Assumes DATA_W = 8*LANES.
module sram_ctl_bus #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              finish,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data
);

    localparam int LANE_W = DATA_W / LANES;

    logic [LANES-1:0] be_q;

    // Hold the request fields for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            be_q       <= '0;
            mem_be_n   <= '1;
        end else if (launch) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
            mem_be_n   <= ~req_be;
        end else if (finish) begin
            mem_be_n   <= '1;
        end
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] lane_q;
            // Capture one byte lane; disabled lanes read as zero.
            always_ff @(posedge clk) begin
                if (!rst_n)       lane_q <= '0;
                else if (capture) lane_q <= be_q[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
            end
            assign rd_data[l*LANE_W +: LANE_W] = lane_q;
        end
    endgenerate

    // R4: strobes reflect the latched enables whenever they are active.
    a_r4_strobe_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be_n != '1) |-> (mem_be_n == ~be_q));

endmodule

// File: rtl/sram_ctl.sv
// Synchronous controller for a 16-bit asynchronous SRAM with byte
// strobes. Converts nanosecond limits into wait states at elaboration.
// Assumes the pad ring builds the tri-state buffer from dq_out/dq_oe.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS    = 10,
    parameter int ADDR_W           = 16,
    parameter int DATA_W           = 16,
    parameter int T_OE_HIZ_NS      = 7,
    parameter int T_WE_PULSE_NS    = 10,
    parameter int T_WDATA_SETUP_NS = 8,
    parameter int T_ADDR_SETUP_NS  = 10,
    parameter int T_BE_SETUP_NS    = 9,
    parameter int T_ADDR_ACCESS_NS = 15,
    parameter int T_OE_ACCESS_NS   = 7,
    parameter int T_RD_CYCLE_NS    = 15,
    parameter int T_WR_CYCLE_NS    = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    output logic                 ready,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_be,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_be_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_out,
    input  logic [DATA_W-1:0]    mem_dq_in,
    output logic                 mem_dq_oe
);

    localparam int LANES = DATA_W / 8;
    localparam int N_HZ  = ns_to_cycles(T_OE_HIZ_NS, CLK_PERIOD_NS);
    localparam int N_WP  = ns_to_cycles(max2(max2(T_WE_PULSE_NS, T_WDATA_SETUP_NS),
                                             max2(T_ADDR_SETUP_NS, T_BE_SETUP_NS)),
                                        CLK_PERIOD_NS);
    localparam int N_ACC = ns_to_cycles(max2(T_ADDR_ACCESS_NS, T_OE_ACCESS_NS), CLK_PERIOD_NS);
    localparam int N_CYC = ns_to_cycles(max2(T_RD_CYCLE_NS, T_WR_CYCLE_NS), CLK_PERIOD_NS);
    localparam int N_MAX = max2(max2(N_HZ, N_WP), max2(N_ACC, N_CYC));
    localparam int CNT_W = $clog2(N_MAX + 1);

    logic             launch, finish, capture;
    logic             ph_load, ph_zero, cyc_load, cyc_zero;
    logic [CNT_W-1:0] ph_val, cyc_val;

    sram_ctl_seq #(
        .N_HZ(N_HZ), .N_WP(N_WP), .N_ACC(N_ACC), .N_CYC(N_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .ph_zero(ph_zero), .cyc_zero(cyc_zero),
        .ready(ready), .launch(launch), .finish(finish), .capture(capture),
        .ph_load(ph_load), .ph_val(ph_val), .cyc_load(cyc_load), .cyc_val(cyc_val),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
    );

    sram_ctl_waitcnt #(.CNT_W(CNT_W)) u_phase_cnt (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    sram_ctl_waitcnt #(.CNT_W(CNT_W)) u_cycle_cnt (
        .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_val(cyc_val), .zero(cyc_zero)
    );

    sram_ctl_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_bus (
        .clk(clk), .rst_n(rst_n), .launch(launch), .finish(finish), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .rd_data(rd_data)
    );

    // Checker state: lengths of the current write pulse and read window.
    logic [CNT_W-1:0] chk_we_run, chk_rd_run;

    // Count consecutive cycles of write pulse and of read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_we_run <= '0;
            chk_rd_run <= '0;
        end else begin
            chk_we_run <= !mem_we_n ? chk_we_run + 1'b1 : '0;
            chk_rd_run <= !mem_oe_n ? chk_rd_run + 1'b1 : '0;
        end
    end

    // R9: write pulse length is the computed count.
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (chk_we_run == CNT_W'(N_WP)));

    // R3: read window length is the computed count.
    a_r3_read_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (chk_rd_run == CNT_W'(N_ACC)));

    // R8: address and byte strobes hold while chip select is low.
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    // R2: write data does not move during the drive window.
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R7: ready is only offered with the memory deselected.
    a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_ce_n);

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

    localparam int CLK_NS = 4;
    localparam int AW     = 4;
    localparam int DW     = 16;
    localparam int WORDS  = 1 << AW;
    localparam int E_HZ   = (7 + CLK_NS - 1) / CLK_NS;
    localparam int E_WP   = (10 + CLK_NS - 1) / CLK_NS;
    localparam int E_ACC  = (15 + CLK_NS - 1) / CLK_NS;
    localparam int E_CYC  = (15 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic ready, ce_n, oe_n, we_n, dq_oe;
    logic [1:0] be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] rd_data, dq_out, dq_in;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctl #(.CLK_PERIOD_NS(CLK_NS), .ADDR_W(AW), .DATA_W(DW)) u_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_be_n(be_n),
        .mem_addr(mem_addr), .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Memory model: data valid only after the full access window.
    logic [DW-1:0] mem_arr [WORDS];
    logic [DW-1:0] exp_arr [WORDS];
    int rd_run = 0, wr_run = 0, turn_run = 0, gap = 0;
    bit wr_prev = 0, rd_prev = 0, drv_prev = 0, ce_prev_n = 1, have_ce = 0, wr_undriven = 0;
    logic [DW-1:0] wr_dat_l;
    logic [1:0] wr_ben_l, rd_ben_l, cur_be = '0;
    logic [AW-1:0] wr_adr_l, ce_adr_l;
    wire rd_act = !ce_n && !oe_n && we_n;
    wire wr_act = !ce_n && !we_n && (be_n != 2'b11);

    always_comb begin
        for (int l = 0; l < 2; l++) begin
            if (rd_act && !be_n[l])
                dq_in[l*8 +: 8] = (rd_run >= E_ACC) ? mem_arr[mem_addr][l*8 +: 8] : 8'hA5;
            else
                dq_in[l*8 +: 8] = 8'h5A;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_act && dq_oe) chk(0, "R6 contention", 1, 0);
            if (!we_n && !oe_n) chk(0, "R2 oe during write", 0, 1);
            if (rd_act) begin
                rd_run++;
                rd_ben_l = be_n;
            end else begin
                if (rd_prev) begin
                    chk(rd_run == E_ACC, "R3 read window", rd_run, E_ACC);
                    chk(rd_ben_l == ~cur_be, "R4 read strobes", rd_ben_l, ~cur_be);
                end
                rd_run = 0;
            end
            if (wr_act) begin
                wr_run++;
                if (!dq_oe) wr_undriven = 1;
                wr_dat_l = dq_out; wr_ben_l = be_n; wr_adr_l = mem_addr;
            end else if (wr_prev) begin
                chk(wr_run == E_WP, "R9 pulse width", wr_run, E_WP);
                chk(!wr_undriven, "R2 data driven", wr_undriven, 0);
                chk(wr_ben_l == ~cur_be, "R4 write strobes", wr_ben_l, ~cur_be);
                for (int l = 0; l < 2; l++)
                    if (!wr_ben_l[l]) mem_arr[wr_adr_l][l*8 +: 8] = wr_dat_l[l*8 +: 8];
                wr_run = 0; wr_undriven = 0;
            end
            if (!ce_n && we_n && oe_n && !dq_oe) turn_run++;
            if (dq_oe && !drv_prev) chk(turn_run == E_HZ, "R6 turnaround", turn_run, E_HZ);
            gap++;
            if (!ce_n && ce_prev_n) begin
                if (have_ce) chk(gap >= E_CYC, "R7 cycle spacing", gap, E_CYC);
                gap = 0; have_ce = 1; ce_adr_l = mem_addr;
            end
            if (ce_n && !ce_prev_n) chk(mem_addr == ce_adr_l, "R8 address hold", mem_addr, ce_adr_l);
            if (ce_n) turn_run = 0;
            rd_prev = rd_act; wr_prev = wr_act; drv_prev = dq_oe; ce_prev_n = ce_n;
        end
    end

    task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
        @(negedge clk);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be; cur_be = be;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 0;
        chk(!ready, "R7 ready low while busy", ready, 0);
        while (!ready) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return 16'(a * 16'h1357 + k * 16'h0F0F) ^ 16'hC3A5;
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) begin mem_arr[i] = '0; exp_arr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(ce_n && oe_n && we_n, "R1 strobes high", {ce_n, oe_n, we_n}, 3'b111);
        chk(be_n == 2'b11, "R1 byte strobes", be_n, 2'b11);
        chk(!dq_oe, "R1 no drive", dq_oe, 0);
        chk(ready, "R1 ready", ready, 1);
        // R2: full-word writes everywhere
        for (int a = 0; a < WORDS; a++) begin
            host_op(1, a[AW-1:0], pat(a, 0), 2'b11);
            exp_arr[a] = pat(a, 0);
        end
        // R3: full-word reads
        for (int a = 0; a < WORDS; a++) begin
            host_op(0, a[AW-1:0], '0, 2'b11);
            chk(rd_data == exp_arr[a], "R3 read data", rd_data, exp_arr[a]);
        end
        // R4/R5: partial writes, including the empty enable
        for (int a = 0; a < WORDS; a++) begin
            logic [1:0] be = a[1:0];
            host_op(1, a[AW-1:0], pat(a, 1), be);
            exp_arr[a] = (exp_arr[a] & ~lane_mask(be)) | (pat(a, 1) & lane_mask(be));
        end
        // R4/R5: reads under every enable pattern
        for (int a = 0; a < WORDS; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [1:0] be = b[1:0];
                host_op(0, a[AW-1:0], '0, be);
                if (be == 2'b00)
                    chk(rd_data == '0, "R5 disabled lanes zero", rd_data, 0);
                else
                    chk(rd_data == (exp_arr[a] & lane_mask(be)), "R4 lane read",
                        rd_data, exp_arr[a] & lane_mask(be));
            end
        end
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule